// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses for a synchronous DRAM device model or memory controller. A load-mode command writes a mode word. The bank-select lines of that command choose the main mode register or the extended one. From the main register the block takes the burst length, the address order (sequential or interleaved), the CAS latency and a write-single option. The mode word arrives on `ld_addr`, with bit n holding mode bit Mn.

A READ or WRITE command carries a starting column. From the next clock the block emits one column per cycle until the burst is complete. Addresses stay inside an aligned block whose size is the burst length. In full-page mode they wrap around the whole page and continue until a terminate input stops them. A new command arriving during a burst replaces the running burst. A mode word that carries a reserved code is rejected with a one-cycle error pulse.

The sequencer is a three-state machine:
- `ST_IDLE` (no output).
- `ST_FIXED` (a burst of 1, 2, 4 or 8 beats).
- `ST_PAGE` (an open-ended full-page burst).

Its transitions are:
- IDLE→FIXED or IDLE→PAGE on a command.
- FIXED→IDLE after the last beat or on terminate.
- PAGE→IDLE on terminate.
- Any busy state restarts into FIXED or PAGE on a new command.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` and `mode_err` are 0, `ext_mode` is 0 and `cas_lat` is 2. The main register starts as burst length 1, sequential, write-single off.
- R2: Mode bits [2:0] select the burst length: 000→1, 001→2, 010→4, 011→8, 111→full page. Exactly that many addresses are emitted on consecutive cycles, starting the cycle after the command is sampled.
- R3: With bit 3 = 0 (sequential), beat j has the block-select bits of the start column and the low log2(BL) bits equal to (start + j) mod BL.
- R4: With bit 3 = 1 (interleaved), the low log2(BL) bits of beat j equal the start's low bits XOR j. The upper bits are unchanged.
- R5: A full-page burst emits (start + j) mod the page size (256 by default) and does not end by itself.
- R6: When `cmd_stop` is sampled with no command, `col_valid` is 0 from the next cycle.
- R7: With bit 9 = 1, every WRITE is a single beat and reads keep the programmed length. With bit 9 = 0, writes burst like reads. `col_is_wr` marks beats of a WRITE.
- R8: Bits [6:4] = 010 give `cas_lat` 2 and 011 give 3.
- R9: A main-register load is rejected in any of these cases:
  - a burst code of 100, 101 or 110;
  - code 111 with bit 3 = 1;
  - a latency code other than 010 or 011;
  - bits [8:7] not equal to 00.
  A rejected load pulses `mode_err` for one cycle, and the register keeps its contents.
- R10: A load with `ld_ba` = 10 writes `ext_mode`. A load with `ld_ba` = 01 or 11 changes nothing and raises no error.
- R11: A READ or WRITE sampled during a burst abandons it. The new burst's first address appears on the next cycle. If both commands are sampled together, READ wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_mode | input | 1 | Load-mode command strobe |
| ld_ba | input | 2 | Bank select of the load command (register choice) |
| ld_addr | input | 13 | Mode word carried by the load command |
| cmd_rd | input | 1 | READ command strobe |
| cmd_wr | input | 1 | WRITE command strobe |
| col_start | input | COL_W | Starting column of the command |
| cmd_stop | input | 1 | Burst-terminate strobe |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | COL_W | Current column address |
| col_is_wr | output | 1 | The current beat belongs to a WRITE |
| cas_lat | output | 3 | Programmed CAS latency |
| ext_mode | output | 13 | Extended mode register contents |
| mode_err | output | 1 | One-cycle pulse on a rejected load |

## Verification
The bench starts bursts near block and page edges, such as column 0x0E at length 4 and 0xFD in full-page mode. A design that carries into the block-select bits, or that fails to wrap at the page end, then emits an address the scoreboard does not expect.

An interleaved burst from an odd offset separates XOR order from addition. A write with write-single set, followed by a read of the same length, catches a design that shortens reads as well.

Reserved loads use latency codes that differ from the current one, so a design that takes a bad word shows the wrong `cas_lat`. Loads with bank selects 01 and 11 check that nothing moves. A command issued in the middle of a burst, and a terminate issued part way through, check that leftover beats never reach the scoreboard.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    localparam int MODE_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

    localparam logic [MODE_W-1:0] MODE_RST = 13'h020;

    function automatic logic mode_word_ok(input logic [MODE_W-1:0] w);
        logic len_ok;
        logic lat_ok;
        len_ok = (w[2] == 1'b0) || (w[2:0] == 3'b111 && w[3] == 1'b0);
        lat_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
        return len_ok && lat_ok && (w[8:7] == 2'b00);
    endfunction

endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
    import colseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [1:0]        ba,
    input  logic [MODE_W-1:0] din,
    output logic [MODE_W-1:0] main_q,
    output logic [MODE_W-1:0] ext_q,
    output logic              err_q
);
    logic main_sel;
    logic ext_sel;
    logic word_ok;

    always_comb begin
        main_sel = ld && (ba == 2'b00);
        ext_sel  = ld && (ba == 2'b10);
        word_ok  = mode_word_ok(din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= MODE_RST;
            ext_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= main_sel && !word_ok;
            if (main_sel && word_ok) main_q <= din;
            if (ext_sel)             ext_q  <= din;
        end
    end
endmodule

// File: rtl/colseq_step.sv
module colseq_step #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_low;

    always_comb begin
        seq_low = (start + beat) & mask;
        if (ilv) addr = start ^ (beat & mask);
        else     addr = (start & ~mask) | seq_low;
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mode,
    input  logic [1:0]        ld_ba,
    input  logic [12:0]       ld_addr,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [COL_W-1:0]  col_start,
    input  logic              cmd_stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_is_wr,
    output logic [2:0]        cas_lat,
    output logic [12:0]       ext_mode,
    output logic              mode_err
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    seq_state_e       state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [COL_W-1:0] start_q, beat_q, mask_q;
    logic             ilv_q, wr_q;

    logic             go, new_wr, new_single, new_page;
    logic [1:0]       new_k;
    logic [COL_W-1:0] new_mask;

    colseq_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_mode),
        .ba     (ld_ba),
        .din    (ld_addr),
        .main_q (mode_q),
        .ext_q  (ext_mode),
        .err_q  (mode_err)
    );

    colseq_step #(.COL_W(COL_W)) u_step (
        .start (start_q),
        .beat  (beat_q),
        .mask  (mask_q),
        .ilv   (ilv_q),
        .addr  (col_addr)
    );

    // Decode the mode register for a command sampled this cycle.
    always_comb begin
        go         = cmd_rd || cmd_wr;
        new_wr     = cmd_wr && !cmd_rd;
        new_single = new_wr && mode_q[9];
        new_page   = !new_single && (mode_q[2:0] == 3'b111);
        new_k      = new_single ? 2'd0 : mode_q[1:0];
        new_mask   = new_page ? '1 : ((ONE << new_k) - ONE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = new_page ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (go)                               state_d = new_page ? ST_PAGE : ST_FIXED;
                else if (cmd_stop || beat_q == mask_q) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (go)            state_d = new_page ? ST_PAGE : ST_FIXED;
                else if (cmd_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else if (go) begin
            start_q <= col_start;
            beat_q  <= '0;
            mask_q  <= new_mask;
            ilv_q   <= mode_q[3] && !new_page;
            wr_q    <= new_wr;
        end else if (state_d != ST_IDLE) begin
            beat_q  <= beat_q + ONE;
        end
    end

    always_comb begin
        col_valid = (state_q != ST_IDLE);
        col_is_wr = col_valid && wr_q;
        cas_lat   = mode_q[6:4];
    end
endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_mode,
    input logic [1:0]       ld_ba,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic [COL_W-1:0] col_start,
    input logic             cmd_stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic [2:0]       cas_lat,
    input logic [12:0]      ext_mode,
    input logic             mode_err,
    input logic [COL_W-1:0] start_q,
    input logic [COL_W-1:0] mask_q
);
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |=> (col_valid && col_addr == $past(col_start)));

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_rd && !cmd_wr) |=> !col_valid);

    p_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> (((col_addr ^ start_q) & ~mask_q) == '0));

    p_err_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $stable(cas_lat));

    p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(ld_mode && ld_ba == 2'b00));

    p_ext_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mode && ld_ba[0]) |=> ($stable(ext_mode) && !mode_err));

    p_cas_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 3'd2 || cas_lat == 3'd3));
endmodule

bind burst_col_seq colseq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_mode   (ld_mode),
    .ld_ba     (ld_ba),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .col_start (col_start),
    .cmd_stop  (cmd_stop),
    .col_valid (col_valid),
    .col_addr  (col_addr),
    .cas_lat   (cas_lat),
    .ext_mode  (ext_mode),
    .mode_err  (mode_err),
    .start_q   (start_q),
    .mask_q    (mask_q)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
    localparam int COL_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_mode = 1'b0;
    logic [1:0]        ld_ba = 2'b00;
    logic [12:0]       ld_addr = '0;
    logic              cmd_rd = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [COL_W-1:0]  col_start = '0;
    logic              cmd_stop = 1'b0;
    logic              col_valid;
    logic [COL_W-1:0]  col_addr;
    logic              col_is_wr;
    logic [2:0]        cas_lat;
    logic [12:0]       ext_mode;
    logic              mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [COL_W:0] exp_q[$];
    string          tag_q[$];

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && col_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 extra beat", int'(col_addr), -1);
            end else begin
                logic [COL_W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({col_is_wr, col_addr} == e, t, int'({col_is_wr, col_addr}), int'(e));
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    function automatic logic [12:0] mk(input bit m9, input logic [2:0] cl,
                                       input bit ilv, input logic [2:0] bl);
        return {3'b000, m9, 2'b00, cl, ilv, bl};
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int j,
                                                 input int k, input bit ilv, input bit page);
        logic [COL_W-1:0] m;
        m = page ? '1 : COL_W'((1 << k) - 1);
        if (page) return s + COL_W'(j);
        if (ilv)  return s ^ (COL_W'(j) & m);
        return (s & ~m) | ((s + COL_W'(j)) & m);
    endfunction

    task automatic push_beats(input bit wr, input logic [COL_W-1:0] s, input int n,
                              input int k, input bit ilv, input bit page, input string tag);
        for (int j = 0; j < n; j++) begin
            exp_q.push_back({wr, exp_col(s, j, k, ilv, page)});
            tag_q.push_back(tag);
        end
    endtask

    task automatic load(input logic [1:0] ba, input logic [12:0] v, input bit e_err,
                        input int e_cas, input string tag);
        @(negedge clk);
        ld_mode = 1'b1; ld_ba = ba; ld_addr = v;
        @(negedge clk);
        ld_mode = 1'b0;
        chk(mode_err == e_err, {tag, " err"}, int'(mode_err), int'(e_err));
        chk(cas_lat == 3'(e_cas), {tag, " cas"}, int'(cas_lat), e_cas);
        @(negedge clk);
        chk(mode_err == 1'b0, {tag, " err pulse"}, int'(mode_err), 0);
    endtask

    task automatic issue(input bit wr, input logic [COL_W-1:0] s);
        @(negedge clk);
        cmd_rd = !wr; cmd_wr = wr; col_start = s;
        @(negedge clk);
        cmd_rd = 1'b0; cmd_wr = 1'b0;
    endtask

    task automatic settle(input int cyc, input string tag);
        repeat (cyc) @(negedge clk);
        chk(col_valid == 1'b0, {tag, " idle"}, int'(col_valid), 0);
        chk(exp_q.size() == 0, {tag, " beats left"}, exp_q.size(), 0);
    endtask

    task automatic burst(input bit wr, input logic [COL_W-1:0] s, input int k,
                         input bit ilv, input string tag);
        push_beats(wr, s, 1 << k, k, ilv, 1'b0, tag);
        issue(wr, s);
        settle((1 << k) + 1, tag);
    endtask

    task automatic stopped(input bit wr, input logic [COL_W-1:0] s, input int n, input int k,
                           input bit page, input string tag);
        push_beats(wr, s, n, k, 1'b0, page, tag);
        issue(wr, s);
        repeat (n - 1) @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        settle(3, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(col_valid == 1'b0, "R1 valid", int'(col_valid), 0);
        chk(mode_err == 1'b0, "R1 err", int'(mode_err), 0);
        chk(cas_lat == 3'd2, "R1 cas", int'(cas_lat), 2);
        chk(ext_mode == 13'h0, "R1 ext", int'(ext_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        burst(1'b0, 8'h35, 0, 1'b0, "R1 default length 1");

        // R2 R3 R8: length 4 sequential, latency 3
        load(2'b00, mk(0, 3'b011, 0, 3'b010), 1'b0, 3, "R8 load cl3");
        burst(1'b0, 8'h0E, 2, 1'b0, "R3 seq bl4 wrap");
        // R4 interleaved length 8
        load(2'b00, mk(0, 3'b010, 1, 3'b011), 1'b0, 2, "R8 load cl2");
        burst(1'b0, 8'h15, 3, 1'b1, "R4 ilv bl8");
        burst(1'b1, 8'hFA, 3, 1'b1, "R4 ilv bl8 write");
        // R2 length 2 write
        load(2'b00, mk(0, 3'b010, 0, 3'b001), 1'b0, 2, "R2 load bl2");
        burst(1'b1, 8'hFF, 1, 1'b0, "R2 seq bl2 write");
        // R7 write single
        load(2'b00, mk(1, 3'b011, 0, 3'b011), 1'b0, 3, "R7 load single");
        burst(1'b1, 8'h43, 0, 1'b0, "R7 write single");
        burst(1'b0, 8'h43, 3, 1'b0, "R7 read still bursts");
        // R6 terminate of fixed burst
        stopped(1'b0, 8'h10, 3, 3, 1'b0, "R6 stop fixed");
        // R5 full page
        load(2'b00, mk(0, 3'b011, 0, 3'b111), 1'b0, 3, "R5 load page");
        stopped(1'b0, 8'hFD, 6, 0, 1'b1, "R5 page wrap");
        stopped(1'b1, 8'h80, 20, 0, 1'b1, "R5 page long");

        // R11 restart mid-burst
        load(2'b00, mk(0, 3'b011, 0, 3'b011), 1'b0, 3, "R11 load bl8");
        push_beats(1'b0, 8'h20, 2, 3, 1'b0, 1'b0, "R11 first burst");
        push_beats(1'b1, 8'h57, 8, 3, 1'b0, 1'b0, "R11 second burst");
        @(negedge clk);
        cmd_rd = 1'b1; col_start = 8'h20;
        @(negedge clk);
        cmd_rd = 1'b0;
        @(negedge clk);
        cmd_wr = 1'b1; col_start = 8'h57;
        @(negedge clk);
        cmd_wr = 1'b0;
        settle(10, "R11 restart");

        // R9 reserved codes
        load(2'b00, mk(0, 3'b010, 0, 3'b100), 1'b1, 3, "R9 bl 100");
        load(2'b00, mk(0, 3'b001, 0, 3'b011), 1'b1, 3, "R9 cl 001");
        load(2'b00, mk(0, 3'b010, 0, 3'b011) | 13'h080, 1'b1, 3, "R9 op bits");
        load(2'b00, mk(0, 3'b010, 1, 3'b111), 1'b1, 3, "R9 page ilv");
        burst(1'b0, 8'h31, 3, 1'b0, "R9 mode kept");

        // R10 extended and ignored selects
        load(2'b01, mk(0, 3'b010, 0, 3'b000), 1'b0, 3, "R10 ba01");
        load(2'b11, mk(0, 3'b010, 0, 3'b000), 1'b0, 3, "R10 ba11");
        chk(ext_mode == 13'h0, "R10 ext untouched", int'(ext_mode), 0);
        burst(1'b0, 8'h09, 3, 1'b0, "R10 mode unchanged");
        load(2'b10, 13'h1A5, 1'b0, 3, "R10 ext load");
        chk(ext_mode == 13'h1A5, "R10 ext value", int'(ext_mode), 'h1A5);

        finish_run();
    end
endmodule